// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block sits in front of the page walker inside a memory management unit and holds recently used page table entries so that most accesses translate without touching memory. A lookup presents a virtual address, an access kind and the privilege mode. The block splits the address into a page offset and a virtual page number, then splits the page number into a set selector and a tag. It compares the tag against every way of the selected set and, one cycle later, reports exactly one outcome: a hit with the physical address and permission bits, a protection fault, or a miss.

After a miss the walker fetches the entry from memory and installs it through the fill port. A fill whose tag is already present in its set rewrites that way. Otherwise it takes the lowest-numbered empty way, and in a full set it evicts the way named by a per-set round-robin pointer. A flush input empties the whole structure in one cycle. The default geometry is a 32-bit virtual address, 4 KiB pages, 4 sets of 4 ways, and a 20-bit physical page number.

Top module: `tlb_top`

## Requirements
- R1: After reset every line is invalid, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_fault` are 0, and any lookup reports a miss.
- R2: The page offset is `lk_vaddr[11:0]`, the set selector is `lk_vaddr[13:12]` and the tag is `lk_vaddr[31:14]`. On a fill, the set is `fill_vpn[1:0]` and the tag is `fill_vpn[19:2]`. A hit needs a valid line in the selected set whose stored tag equals the lookup tag, so the same tag in a different set misses.
- R3: A lookup presented with `lk_valid` in the cycle ending at edge k has its response registered at edge k. At that point `rsp_valid` is 1. On a hit, `rsp_paddr` is the stored page number concatenated with the unchanged offset, and `rsp_perm` is the stored bits {sup, rd, wr, ex} from bit 3 down to bit 0.
- R4: A lookup that finds no matching valid line gives `rsp_miss`=1 and `rsp_paddr`=0.
- R5: The access kind `lk_acc` is encoded as 0 read, 1 write, 2 fetch, and 3 is treated as read; `lk_user`=1 means user mode. A matching line raises `rsp_fault` instead of `rsp_hit` in any of these cases: a user access to a page with sup=1, a read of a page with rd=0, a write to a page with wr=0, or a fetch from a page with ex=0. A fault gives `rsp_paddr`=0.
- R6: While `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is 1. While `rsp_valid` is 0, all three are 0.
- R7: A fill presented in one cycle is visible to a lookup in the next cycle. A lookup in the same cycle as the fill sees the old contents.
- R8: A fill whose tag is already valid in its set overwrites that way, so the set never holds two copies of one tag.
- R9: A fill with a new tag takes the lowest-numbered invalid way of its set. When the set is full, it evicts the way at that set's round-robin pointer and advances the pointer by one, wrapping after the last way. The pointer starts at way 0 and moves only on such evictions.
- R10: A flush invalidates every line and returns every pointer to way 0 at the next edge. A fill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_user | input | 1 | 1 for a user-mode access |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_vpn | input | 20 | Virtual page number of the entry |
| fill_ppn | input | 20 | Physical page number of the entry |
| fill_perm | input | 4 | Entry permission bits {sup, rd, wr, ex} |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry for this page |
| rsp_fault | output | 1 | Entry found but the access is not permitted |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_perm | output | 4 | Permission bits of the matching entry, else 0 |

## Verification
The table of lookups runs against four preloaded entries, with offsets at 0x000, 0xFFF and values in between. It covers every access kind in both privilege modes, so it separates a correct page-number and offset splice from a wrong one, and a supervisor or missing-right fault from a hit. Neighbouring tags in the same set and equal tags in other sets separate a correct index and tag split from a wrong one. Directed sequences fill one set past capacity, before and after a flush, to tell lowest-invalid placement and round-robin eviction from other victim choices. A refill of a resident tag followed by those evictions exposes a duplicated way, and same-cycle fill with lookup or with flush pins down the ordering.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W  = 32;
  parameter int OFF_W = 12;
  parameter int IDX_W = 2;
  parameter int WAYS  = 4;
  parameter int PPN_W = 20;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PA_W  = PPN_W + OFF_W;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             sup;
    logic             rd;
    logic             wr;
    logic             ex;
  } pte_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [WAYS-1:0]            rd_vld,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  output pte_t [WAYS-1:0]            rd_pte,
  input  logic [IDX_W-1:0]           fill_idx,
  output logic [WAYS-1:0]            fs_vld,
  output logic [WAYS-1:0][TAG_W-1:0] fs_tag,
  output logic [WAY_W-1:0]           fs_ptr,
  input  logic                       wr_en,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  pte_t                       wr_pte,
  input  logic                       ptr_adv,
  input  logic                       flush
);
  logic [SETS-1:0][WAYS-1:0]  vld_q, vld_d;
  logic [SETS-1:0][WAY_W-1:0] ptr_q, ptr_d;
  logic [TAG_W-1:0]           tag_q [SETS][WAYS];
  pte_t                       pte_q [SETS][WAYS];
  logic                       wr_go;

  assign wr_go = wr_en & ~flush;

  // next-state of valid bits and replacement pointers
  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
      ptr_d = '0;
    end else if (wr_en) begin
      vld_d[fill_idx][wr_way] = 1'b1;
      if (ptr_adv) begin
        if (ptr_q[fill_idx] == WAY_W'(WAYS - 1)) ptr_d[fill_idx] = '0;
        else ptr_d[fill_idx] = ptr_q[fill_idx] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  // payload storage: write-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_go) begin
      tag_q[fill_idx][wr_way] <= wr_tag;
      pte_q[fill_idx][wr_way] <= wr_pte;
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_port
      assign rd_vld[w] = vld_q[rd_idx][w];
      assign rd_tag[w] = tag_q[rd_idx][w];
      assign rd_pte[w] = pte_q[rd_idx][w];
      assign fs_vld[w] = vld_q[fill_idx][w];
      assign fs_tag[w] = tag_q[fill_idx][w];
    end
  endgenerate

  assign fs_ptr = ptr_q[fill_idx];

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0 && ptr_q == '0));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !flush) |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
(
  input  logic [WAYS-1:0]            fs_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] fs_tag,
  input  logic [WAY_W-1:0]           fs_ptr,
  input  logic [TAG_W-1:0]           new_tag,
  output logic [WAY_W-1:0]           way,
  output logic                       adv
);
  logic             tag_seen;
  logic [WAY_W-1:0] tag_way;
  logic             hole_seen;
  logic [WAY_W-1:0] hole_way;

  always_comb begin
    tag_seen  = 1'b0;
    tag_way   = '0;
    hole_seen = 1'b0;
    hole_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (fs_vld[w] && fs_tag[w] == new_tag) begin
        tag_seen = 1'b1;
        tag_way  = WAY_W'(w);
      end
      if (!fs_vld[w]) begin
        hole_seen = 1'b1;
        hole_way  = WAY_W'(w);
      end
    end
    if (tag_seen)       way = tag_way;
    else if (hole_seen) way = hole_way;
    else                way = fs_ptr;
    adv = ~tag_seen & ~hole_seen;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            rd_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  input  pte_t [WAYS-1:0]            rd_pte,
  input  logic [TAG_W-1:0]           lk_tag,
  output logic                       hit,
  output pte_t                       pte
);
  logic [WAYS-1:0] way_hit;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign way_hit[w] = rd_vld[w] && (rd_tag[w] == lk_tag);
    end
  endgenerate

  always_comb begin
    pte = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) pte = pte | rd_pte[w];
    end
  end

  assign hit = |way_hit;

  // R8
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [3:0] perm,
  input  acc_e       acc,
  input  logic       user,
  output logic       fault
);
  logic p_sup, p_rd, p_wr, p_ex;
  assign {p_sup, p_rd, p_wr, p_ex} = perm;

  always_comb begin
    unique case (acc)
      ACC_WRITE: fault = ~p_wr;
      ACC_FETCH: fault = ~p_ex;
      default:   fault = ~p_rd;
    endcase
    if (user && p_sup) fault = 1'b1;
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [3:0]       fill_perm,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [3:0]       rsp_perm
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // address split
  logic [OFF_W-1:0] lk_off;
  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_off = lk_vaddr[OFF_W-1:0];
  assign lk_idx = lk_vaddr[OFF_W+IDX_W-1:OFF_W];
  assign lk_tag = lk_vaddr[VA_W-1:OFF_W+IDX_W];
  assign fl_idx = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

  pte_t fl_pte;
  assign fl_pte = '{ppn: fill_ppn, sup: fill_perm[3], rd: fill_perm[2],
                    wr: fill_perm[1], ex: fill_perm[0]};

  logic [WAYS-1:0]            rd_vld, fs_vld;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag, fs_tag;
  pte_t [WAYS-1:0]            rd_pte;
  logic [WAY_W-1:0]           fs_ptr, vic_way;
  logic                       vic_adv;

  tlb_store u_store (
    .clk(clk), .rst_n(rst_ni),
    .rd_idx(lk_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_pte(rd_pte),
    .fill_idx(fl_idx), .fs_vld(fs_vld), .fs_tag(fs_tag), .fs_ptr(fs_ptr),
    .wr_en(fill_valid), .wr_way(vic_way), .wr_tag(fl_tag), .wr_pte(fl_pte),
    .ptr_adv(vic_adv), .flush(flush)
  );

  tlb_victim u_victim (
    .fs_vld(fs_vld), .fs_tag(fs_tag), .fs_ptr(fs_ptr),
    .new_tag(fl_tag), .way(vic_way), .adv(vic_adv)
  );

  logic m_hit;
  pte_t m_pte;
  tlb_match u_match (
    .clk(clk), .rst_n(rst_ni),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_pte(rd_pte),
    .lk_tag(lk_tag), .hit(m_hit), .pte(m_pte)
  );

  logic [3:0] m_perm;
  logic       m_fault;
  assign m_perm = {m_pte.sup, m_pte.rd, m_pte.wr, m_pte.ex};

  tlb_perm u_perm (
    .perm(m_perm), .acc(acc_e'(lk_acc)), .user(lk_user), .fault(m_fault)
  );

  // response next-state
  logic            hit_d, miss_d, fault_d;
  logic [PA_W-1:0] paddr_d;
  logic [3:0]      perm_d;
  always_comb begin
    hit_d   = lk_valid & m_hit & ~m_fault;
    fault_d = lk_valid & m_hit & m_fault;
    miss_d  = lk_valid & ~m_hit;
    paddr_d = (m_hit & ~m_fault) ? {m_pte.ppn, lk_off} : '0;
    perm_d  = m_hit ? m_perm : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
      rsp_fault <= fault_d;
      if (lk_valid) begin
        rsp_paddr <= paddr_d;
        rsp_perm  <= perm_d;
      end
    end
  end

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R3
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_valid |=> rsp_valid);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (lk_valid && m_hit && !m_fault) |=> rsp_paddr[OFF_W-1:0] == $past(lk_off));
endmodule

// File: tb/sim_tlb_top.sv
module sim_tlb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_user, fill_valid, flush;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_acc;
  logic [19:0] fill_vpn, fill_ppn;
  logic [3:0]  fill_perm;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_perm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tlb_top u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_user(lk_user), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm)
  );

  // class codes: 0 miss, 1 hit, 2 fault, 3 other
  // {vaddr[32], acc[2], user[1], cls[2], paddr[32]}
  localparam int NV = 14;
  localparam logic [68:0] VEC [NV] = '{
    {32'h00001123, 2'd0, 1'b1, 2'd1, 32'hABCDE123},
    {32'h00001FFF, 2'd1, 1'b1, 2'd1, 32'hABCDEFFF},
    {32'h00001000, 2'd2, 1'b1, 2'd2, 32'h00000000},
    {32'h12342456, 2'd0, 1'b1, 2'd2, 32'h00000000},
    {32'h12342456, 2'd0, 1'b0, 2'd1, 32'h00777456},
    {32'h12342010, 2'd1, 1'b0, 2'd2, 32'h00000000},
    {32'h12342010, 2'd2, 1'b0, 2'd1, 32'h00777010},
    {32'h00005ABC, 2'd2, 1'b1, 2'd1, 32'h55555ABC},
    {32'h00002000, 2'd0, 1'b1, 2'd0, 32'h00000000},
    {32'h00004001, 2'd0, 1'b0, 2'd2, 32'h00000000},
    {32'h00004002, 2'd1, 1'b1, 2'd1, 32'h0F0F0002},
    {32'h00000001, 2'd0, 1'b0, 2'd0, 32'h00000000},
    {32'h00011000, 2'd0, 1'b0, 2'd0, 32'h00000000},
    {32'h0000500C, 2'd3, 1'b1, 2'd1, 32'h5555500C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cls_now();
    if (!rsp_valid) return 2'd3;
    case ({rsp_hit, rsp_miss, rsp_fault})
      3'b100:  return 2'd1;
      3'b010:  return 2'd0;
      3'b001:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic usr);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = usr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] pm);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = pm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_cls(input string req, input logic [31:0] va, input logic [1:0] cls);
    look(va, 2'd0, 1'b0);
    chk(req, {30'd0, cls_now()}, {30'd0, cls});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_acc = '0; lk_user = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset flags", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(32'h00001000, 2'd0, 1'b0);
    chk("R1 empty lookup misses", {30'd0, cls_now()}, 32'd0);
    @(negedge clk);
    chk("R6 idle after lookup", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);

    // preload, perm = {sup, rd, wr, ex}
    fill(20'h00001, 20'hABCDE, 4'b0110);
    fill(20'h12342, 20'h00777, 4'b1101);
    fill(20'h00005, 20'h55555, 4'b0101);
    fill(20'h00004, 20'h0F0F0, 4'b0010);

    // R2 R3 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][68:37], VEC[i][36:35], VEC[i][34]);
      chk($sformatf("R5 R2 vec%0d class", i), {30'd0, cls_now()}, {30'd0, VEC[i][33:32]});
      chk($sformatf("R3 R4 vec%0d paddr", i), rsp_paddr, VEC[i][31:0]);
    end

    // R3 permission readback
    look(32'h12342000, 2'd0, 1'b0);
    chk("R3 perm bits", {28'd0, rsp_perm}, 32'hD);

    // R7 same-cycle fill and lookup
    fill_valid = 1'b1; fill_vpn = 20'h00008; fill_ppn = 20'h22222; fill_perm = 4'b0111;
    lk_valid = 1'b1; lk_vaddr = 32'h00008004; lk_acc = 2'd0; lk_user = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk("R7 same-cycle lookup sees old", {30'd0, cls_now()}, 32'd0);
    look(32'h00008004, 2'd0, 1'b1);
    chk("R7 next-cycle lookup hits", rsp_paddr, 32'h22222004);

    // R8 overwrite resident tag in set 1 (ways: 0=vpn1, 1=vpn5)
    fill(20'h00001, 20'h11111, 4'b0110);
    look(32'h00001234, 2'd0, 1'b1);
    chk("R8 overwrite new ppn", rsp_paddr, 32'h11111234);

    // R9 fill set 1 to capacity then evict round-robin
    fill(20'h00009, 20'h33333, 4'b0100);
    fill(20'h0000D, 20'h44444, 4'b0100);
    fill(20'h00011, 20'h66666, 4'b0100);
    expect_cls("R9 way0 evicted first", 32'h00001000, 2'd0);
    expect_cls("R9 R8 way1 kept", 32'h00005000, 2'd1);
    expect_cls("R9 newest present", 32'h00011000, 2'd1);
    expect_cls("R9 other set untouched", 32'h00004000, 2'd2);
    fill(20'h00015, 20'h77777, 4'b0100);
    expect_cls("R9 way1 evicted second", 32'h00005000, 2'd0);
    expect_cls("R9 way2 kept", 32'h00009000, 2'd1);

    // R10 flush with simultaneous fill
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00020; fill_ppn = 20'h88888; fill_perm = 4'b0100;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    expect_cls("R10 flushed entry misses", 32'h12342000, 2'd0);
    expect_cls("R10 fill with flush dropped", 32'h00020000, 2'd0);

    // R10 pointer back at way 0: five fills into set 1
    fill(20'h00001, 20'h10001, 4'b0100);
    fill(20'h00005, 20'h10005, 4'b0100);
    fill(20'h00009, 20'h10009, 4'b0100);
    fill(20'h0000D, 20'h1000D, 4'b0100);
    fill(20'h00011, 20'h10011, 4'b0100);
    expect_cls("R10 pointer reset evicts way0", 32'h00001000, 2'd0);
    expect_cls("R10 way1 kept after flush", 32'h00005000, 2'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule